// File: doc/BRIEF.md
# Audio DMA Control Register Bank

This block is the register file of an audio serial-port controller. It hangs on a simple 32-bit word-aligned register bus and holds seventeen 32-bit words. Among them are the control and mode words, the FIFO and prescaler settings, the transmit and receive data words, the DMA control word, the start addresses, the transfer size, the transfer count and four buffer-level addresses. A write merges the incoming data with the stored word under a mask that belongs to that register.

Several actions have side effects. Clearing the soft-reset bit restores the whole bank. The DMA control word carries write-one-to-clear strobes for its interrupt flags. Changing the DMA enable bit is reported on a pulse output. A write to the size word can force the transfer count to zero. The DMA engine sets flags and loads the count through plain side inputs. A single registered level interrupt summarises the flag activity.

The bus is plain: `wr_en` and `rd_en` each take effect in the cycle they are high, and nothing is ever stalled. Read data comes back one cycle later together with `rd_valid`. A bad access is reported by a one-cycle `err` pulse one cycle after the access.

Top module: `audio_dma_regbank`

## Requirements
- R1: Legal byte addresses are word-aligned (addr[1:0]=0) and range from 0x00 to 0x40. Any read or write elsewhere raises `err` in the next cycle, changes no register, and a read of such an address returns 0.
- R2: `rd_en` produces `rd_valid` in the next cycle, with `rdata` holding the stored word. After reset the size word (0x28) reads 0x7FFF0000 and every other word reads 0, and `irq`, `err` and `dma_en` are 0.
- R3: A write to the control word (0x00) changes only the bits set in 0x8295007F. All other bits keep their value.
- R4: A write to 0x00 with bit 31 = 0, while the stored bit 31 is 1, is a soft reset. Every other word returns to its reset value, the control word takes the written data under its mask, and `irq` is 0 in the next cycle. A soft reset wins over engine set inputs in the same cycle.
- R5: A write to the DMA control word (0x20) changes only the bits set in 0xFF0000FB. Bit 2 and bits 23:16 are never loaded from the bus.
- R6: In a legal write to 0x20, data bit 16+i clears flag bit 20+i (i = 0..3) and data bit 1 clears flag bit 2. A clear that drops a flag that was set also drops `irq` in the next cycle.
- R7: `lvl_set[i]` sets flag bit 20+i and `done_set` sets flag bit 2. Either one makes `irq` 1 in the next cycle. When a set and a clear hit the same flag in one cycle, the set wins.
- R8: A legal write to 0x20 whose bit 0 differs from the stored enable pulses `dma_en_chg` for one cycle. When the enable goes from 1 to 0, `irq` also drops, unless a set input is active in that cycle. `dma_en` mirrors stored bit 0.
- R9: A write to 0x20 with bit 0 = 1 is illegal when bit 5 = 0, bit 3 = 0 or bit 6 = 1. Such a write raises `err` and leaves the word, including its flags, unchanged.
- R10: Writing 0 to the size word (0x28) raises `err` and leaves it unchanged. A nonzero write is stored in full. If its bits 31:16 are less than or equal to the current count, the count becomes 0.
- R11: The count word (0x2C) cannot be written from the bus. Such a write raises `err` and leaves it unchanged. `cnt_ld` loads `cnt_val` into bits 23:0, and bits 31:24 read 0. A count-zeroing size write wins over a load in the same cycle.
- R12: The remaining words (0x04 to 0x1C, 0x24, and 0x30 to 0x40) store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| err | output | 1 | Illegal-access pulse |
| lvl_set | input | LVL_N | Engine sets buffer-level flags |
| done_set | input | 1 | Engine sets the DMA flag |
| cnt_ld | input | 1 | Engine loads the transfer count |
| cnt_val | input | CNT_W | Transfer count value to load |
| dma_en | output | 1 | Stored DMA enable |
| dma_en_chg | output | 1 | Pulse on any DMA enable change |
| irq | output | 1 | Level interrupt |

## Verification
The DMA control word can see a bus clear strobe and an engine set of the same flag in one cycle. The bench provokes this by holding `done_set` high during a write that carries the flag-2 clear strobe. It then reads the word back, which must still show bit 2 set, and checks that `irq` is still high. A second collision is a pending interrupt meeting a soft-reset release. Here the bench checks that `irq` falls and that every word reads its reset value.

// File: rtl/ardb_pkg.sv
package ardb_pkg;
  localparam int NREG   = 17;
  localparam int I_CTRL = 0;
  localparam int I_AHB  = 8;
  localparam int I_SIZE = 10;
  localparam int I_CNT  = 11;
  localparam logic [31:0] CTRL_WMASK = 32'h8295_007F;
  localparam logic [31:0] AHB_WMASK  = 32'hFF00_00FB;
  localparam logic [31:0] SIZE_RST   = 32'h7FFF_0000;

  function automatic logic [31:0] wmask(input int idx);
    case (idx)
      I_CTRL:  return CTRL_WMASK;
      I_AHB:   return AHB_WMASK;
      I_CNT:   return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] rstval(input int idx);
    return (idx == I_SIZE) ? SIZE_RST : 32'h0;
  endfunction
endpackage

// File: rtl/ardb_decode.sv
module ardb_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 17,
  localparam int IW    = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IW-1:0]     idx,
  output logic              legal
);
  localparam logic [ADDR_W-3:0] LIMIT = (ADDR_W-2)'(NREG);
  logic [ADDR_W-3:0] word;

  assign word  = addr[ADDR_W-1:2];
  assign legal = (addr[1:0] == 2'b00) && (word < LIMIT);
  assign idx   = word[IW-1:0];
endmodule

// File: rtl/ardb_ahb_ctrl.sv
module ardb_ahb_ctrl #(
  parameter int LVL_N = 4
) (
  input  logic [31:0]      cur,
  input  logic [31:0]      wdata,
  input  logic             wr,
  input  logic [LVL_N-1:0] lvl_set,
  input  logic             done_set,
  output logic [31:0]      nxt,
  output logic             illegal,
  output logic             clr_hit,
  output logic             en_chg,
  output logic             en_fall
);
  logic acc;

  assign illegal = wr && wdata[0] && (!wdata[5] || !wdata[3] || wdata[6]);
  assign acc     = wr && !illegal;
  assign en_chg  = acc && (wdata[0] != cur[0]);
  assign en_fall = en_chg && cur[0];

  always_comb begin
    nxt     = cur;
    clr_hit = 1'b0;
    if (acc) begin
      for (int i = 0; i < LVL_N; i++) begin
        if (wdata[16+i] && cur[20+i]) begin
          nxt[20+i] = 1'b0;
          clr_hit   = 1'b1;
        end
      end
      if (wdata[1] && cur[2]) begin
        nxt[2]  = 1'b0;
        clr_hit = 1'b1;
      end
      nxt = (nxt & ~ardb_pkg::AHB_WMASK) | (wdata & ardb_pkg::AHB_WMASK);
    end
    for (int i = 0; i < LVL_N; i++) begin
      if (lvl_set[i]) nxt[20+i] = 1'b1;
    end
    if (done_set) nxt[2] = 1'b1;
  end
endmodule

// File: rtl/ardb_irq.sv
module ardb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic set_any,
  input  logic drop,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        irq <= 1'b0;
    else if (soft_rst) irq <= 1'b0;
    else if (set_any)  irq <= 1'b1;
    else if (drop)     irq <= 1'b0;
  end
endmodule

// File: rtl/audio_dma_regbank.sv
module audio_dma_regbank #(
  parameter int ADDR_W = 8,
  parameter int LVL_N  = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rd_valid,
  output logic              err,
  input  logic [LVL_N-1:0]  lvl_set,
  input  logic              done_set,
  input  logic              cnt_ld,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              dma_en,
  output logic              dma_en_chg,
  output logic              irq
);
  import ardb_pkg::*;
  localparam int IW = $clog2(NREG);

  logic [31:0] regs_q [NREG];
  logic [31:0] nxt    [NREG];
  logic [IW-1:0] idx;
  logic legal, wr_ok, soft_rst, size_bad, cnt_bad, size_zero_cnt;
  logic [31:0] ahb_nxt;
  logic ahb_illegal, clr_hit, en_chg, en_fall;

  ardb_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr(addr), .idx(idx), .legal(legal));

  assign wr_ok    = wr_en && legal;
  assign soft_rst = wr_ok && (int'(idx) == I_CTRL) && !wdata[31] && regs_q[I_CTRL][31];
  assign size_bad = wr_ok && (int'(idx) == I_SIZE) && (wdata == 32'h0);
  assign cnt_bad  = wr_ok && (int'(idx) == I_CNT);
  assign size_zero_cnt = wr_ok && (int'(idx) == I_SIZE) && !size_bad &&
    ({{(CNT_W-16){1'b0}}, wdata[31:16]} <= regs_q[I_CNT][CNT_W-1:0]);

  ardb_ahb_ctrl #(.LVL_N(LVL_N)) u_ahb (
    .cur(regs_q[I_AHB]), .wdata(wdata),
    .wr(wr_ok && (int'(idx) == I_AHB)),
    .lvl_set(lvl_set), .done_set(done_set),
    .nxt(ahb_nxt), .illegal(ahb_illegal), .clr_hit(clr_hit),
    .en_chg(en_chg), .en_fall(en_fall));

  always_comb begin
    for (int k = 0; k < NREG; k++) nxt[k] = regs_q[k];
    if (wr_ok && !size_bad && (int'(idx) != I_CNT) && (int'(idx) != I_AHB))
      nxt[idx] = (regs_q[idx] & ~wmask(int'(idx))) | (wdata & wmask(int'(idx)));
    nxt[I_AHB] = ahb_nxt;
    if (cnt_ld) nxt[I_CNT] = 32'(cnt_val);
    if (size_zero_cnt) nxt[I_CNT] = 32'h0;
    if (soft_rst) begin
      for (int k = 0; k < NREG; k++) nxt[k] = rstval(k);
      nxt[I_CTRL] = wdata & CTRL_WMASK;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= rstval(g);
      else        regs_q[g] <= nxt[g];
    end
  end

  ardb_irq u_irq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_any((|lvl_set) || done_set),
    .drop(clr_hit || en_fall), .irq(irq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata      <= 32'h0;
      rd_valid   <= 1'b0;
      err        <= 1'b0;
      dma_en_chg <= 1'b0;
    end else begin
      rd_valid   <= rd_en;
      if (rd_en) rdata <= legal ? regs_q[idx] : 32'h0;
      err        <= ((wr_en || rd_en) && !legal) || size_bad || cnt_bad || ahb_illegal;
      dma_en_chg <= en_chg && !soft_rst;
    end
  end

  assign dma_en = regs_q[I_AHB][0];
endmodule

// File: rtl/ardb_checker.sv
module ardb_checker #(
  parameter int ADDR_W = 8,
  parameter int LVL_N  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              rd_valid,
  input logic              err,
  input logic [LVL_N-1:0]  lvl_set,
  input logic              done_set,
  input logic              cnt_ld,
  input logic              dma_en,
  input logic              dma_en_chg,
  input logic              irq,
  input logic              ctrl_srst,
  input logic [31:0]       size_q,
  input logic [23:0]       cnt_q
);
  AST_BAD_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && (addr > ADDR_W'(8'h40)) |=> err); // R1
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_SRST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == '0) && !wdata[31] && ctrl_srst |=> !irq && (size_q == 32'h7FFF_0000)); // R4
  AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lvl_set) || done_set) && !(wr_en && (addr == '0) && !wdata[31] && ctrl_srst) |=> irq); // R7
  AST_EN_FALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == ADDR_W'(8'h20)) && !wdata[0] && dma_en && (lvl_set == '0) && !done_set
    |=> !irq && dma_en_chg && !dma_en); // R8
  AST_SIZE_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == ADDR_W'(8'h28)) && (wdata == 32'h0) |=> err && (size_q == $past(size_q))); // R10
  AST_CNT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == ADDR_W'(8'h2C)) && !cnt_ld |=> err && (cnt_q == $past(cnt_q))); // R11
endmodule

bind audio_dma_regbank ardb_checker #(.ADDR_W(ADDR_W), .LVL_N(LVL_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_valid(rd_valid), .err(err), .lvl_set(lvl_set),
  .done_set(done_set), .cnt_ld(cnt_ld), .dma_en(dma_en),
  .dma_en_chg(dma_en_chg), .irq(irq), .ctrl_srst(regs_q[0][31]),
  .size_q(regs_q[10]), .cnt_q(regs_q[11][23:0]));

// File: tb/test_audio_dma_regbank.sv
module test_audio_dma_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rd_valid, err, dma_en, dma_en_chg, irq;
  logic [3:0] lvl_set = '0;
  logic done_set = 1'b0, cnt_ld = 1'b0;
  logic [23:0] cnt_val = '0;

  always #5 clk = ~clk;

  audio_dma_regbank i_audio_dma_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .err(err),
    .lvl_set(lvl_set), .done_set(done_set), .cnt_ld(cnt_ld), .cnt_val(cnt_val),
    .dma_en(dma_en), .dma_en_chg(dma_en_chg), .irq(irq));

  int n_chk = 0, n_fail = 0;
  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag;
    sb.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] l, input logic d);
    lvl_set = l; done_set = d;
    @(negedge clk);
    lvl_set = '0; done_set = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever read data is presented
  initial forever begin
    @(negedge clk);
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 unexpected read act=%h exp=none", rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, rdata, e.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    check("R2 irq after reset", {31'h0, irq}, 32'h0);
    check("R2 dma_en after reset", {31'h0, dma_en}, 32'h0);
    bus_rd(8'h28, 32'h7FFF_0000, "R2 size reset");
    bus_rd(8'h00, 32'h0, "R2 ctrl reset");
    bus_rd(8'h2C, 32'h0, "R2 count reset");
    // R3 control mask
    bus_wr(8'h00, 32'h7FFF_FFFF);
    bus_rd(8'h00, 32'h0295_007F, "R3 ctrl masked");
    bus_wr(8'h00, 32'h0);
    // R12 plain words
    bus_wr(8'h04, 32'h1234_5678);
    bus_rd(8'h04, 32'h1234_5678, "R12 mode word");
    bus_wr(8'h40, 32'hDEAD_BEEF);
    bus_rd(8'h40, 32'hDEAD_BEEF, "R12 last word");
    // R1 illegal addresses
    bus_wr(8'h44, 32'h1);
    check("R1 err on 0x44 write", {31'h0, err}, 32'h1);
    bus_wr(8'h06, 32'h1);
    check("R1 err on misaligned", {31'h0, err}, 32'h1);
    bus_rd(8'h04, 32'h1234_5678, "R1 misaligned write ignored");
    bus_rd(8'h44, 32'h0, "R1 bad read data");
    // R11 count
    cnt_ld = 1'b1; cnt_val = 24'h000100;
    @(negedge clk);
    cnt_ld = 1'b0;
    bus_rd(8'h2C, 32'h0000_0100, "R11 count load");
    bus_wr(8'h2C, 32'h5);
    check("R11 err on count write", {31'h0, err}, 32'h1);
    bus_rd(8'h2C, 32'h0000_0100, "R11 count unchanged");
    // R10 size
    bus_wr(8'h28, 32'h0);
    check("R10 err on zero size", {31'h0, err}, 32'h1);
    bus_rd(8'h28, 32'h7FFF_0000, "R10 size kept");
    bus_wr(8'h28, 32'h0200_0000);
    check("R10 no err legal size", {31'h0, err}, 32'h0);
    bus_rd(8'h2C, 32'h0000_0100, "R10 count kept when size larger");
    bus_wr(8'h28, 32'h0100_0000);
    bus_rd(8'h2C, 32'h0, "R10 count zeroed at equal size");
    bus_rd(8'h28, 32'h0100_0000, "R10 size stored");
    // R9 illegal enable
    bus_wr(8'h20, 32'h0000_0069);
    check("R9 err toggle set", {31'h0, err}, 32'h1);
    bus_rd(8'h20, 32'h0, "R9 word unchanged");
    // R8 enable
    bus_wr(8'h20, 32'h0000_0029);
    check("R8 enable change pulse", {31'h0, dma_en_chg}, 32'h1);
    check("R8 dma_en high", {31'h0, dma_en}, 32'h1);
    // R5 mask
    bus_wr(8'h20, 32'h00FF_002F);
    check("R5 no change pulse", {31'h0, dma_en_chg}, 32'h0);
    bus_rd(8'h20, 32'h0000_002B, "R5 ahb masked");
    bus_wr(8'h20, 32'h0000_0009);
    check("R9 err no reload", {31'h0, err}, 32'h1);
    bus_rd(8'h20, 32'h0000_002B, "R9 ahb unchanged");
    // R7 set
    pulse(4'b0010, 1'b1);
    check("R7 irq raised", {31'h0, irq}, 32'h1);
    bus_rd(8'h20, 32'h0020_002F, "R7 flags set");
    // R6 clear level flag 1 (bit 17), not flag 2
    bus_wr(8'h20, 32'h0002_0029);
    check("R6 irq dropped", {31'h0, irq}, 32'h0);
    bus_rd(8'h20, 32'h0000_002D, "R6 flag cleared");
    // R7 collision: clear of bit 2 with done_set in same cycle
    done_set = 1'b1;
    bus_wr(8'h20, 32'h0000_002B);
    done_set = 1'b0;
    check("R7 set wins irq", {31'h0, irq}, 32'h1);
    bus_rd(8'h20, 32'h0000_002F, "R7 set wins flag");
    bus_wr(8'h20, 32'h0000_002B);
    check("R6 dma flag clear drops irq", {31'h0, irq}, 32'h0);
    bus_rd(8'h20, 32'h0000_002B, "R6 dma flag cleared");
    // R8 enable fall
    pulse(4'b0001, 1'b0);
    check("R7 irq from level 0", {31'h0, irq}, 32'h1);
    bus_wr(8'h20, 32'h0000_0028);
    check("R8 fall pulse", {31'h0, dma_en_chg}, 32'h1);
    check("R8 fall drops irq", {31'h0, irq}, 32'h0);
    check("R8 dma_en low", {31'h0, dma_en}, 32'h0);
    bus_rd(8'h20, 32'h0010_0028, "R8 word after fall");
    // R4 soft reset
    bus_wr(8'h00, 32'h8000_0000);
    pulse(4'b1000, 1'b0);
    check("R4 irq before release", {31'h0, irq}, 32'h1);
    bus_wr(8'h00, 32'h0000_0005);
    check("R4 irq dropped", {31'h0, irq}, 32'h0);
    bus_rd(8'h00, 32'h0000_0005, "R4 ctrl takes write");
    bus_rd(8'h04, 32'h0, "R4 mode reset");
    bus_rd(8'h28, 32'h7FFF_0000, "R4 size reset");
    bus_rd(8'h20, 32'h0, "R4 ahb reset");
    bus_rd(8'h40, 32'h0, "R4 last word reset");
    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(sb.size()), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule